// File: doc/BRIEF.md
# Blanking-Deferred Cycle-Slip Output Buffer

This block sits between a video decoding core and the pixel output. Everything runs on one fixed-frequency system clock. The core delivers pixels at a rate set by the incoming video, and that rate drifts against the system clock. Pixels are held in a small FIFO. An output line timer reads them out as a stream of lines: a horizontal blanking interval that opens with a horizontal sync pulse, then a run of active pixels.

The rate mismatch is absorbed by adding or removing one whole clock cycle of blanking per line. The active region is never stretched or shrunk, so every active line carries the same number of pixels. The output line period moves by at most one clock from the nominal length. The block decides each blanking length from the FIFO occupancy, compared against a target with a deadband. That comparison is made on the last active cycle of the line before.

After reset the FIFO is empty. Input pixels are ignored until the first line-start marker arrives. No line timing starts until the FIFO holds the target number of pixels.

Top module: `slip_out_buffer`

## Requirements
- R1: After reset, pixels offered with `in_valid` high before the first pixel that carries `in_sol` are discarded. The pixel carrying `in_sol` is the first pixel stored, and it is the first pixel seen on `out_data` with `out_active` high.
- R2: After reset, `out_active` and `out_hsync` stay low while the FIFO holds fewer than TARGET pixels. Once it holds TARGET pixels, the first line starts with a blanking interval of exactly LINE_LEN-ACTIVE cycles.
- R3: Every active run (`out_active` high) lasts exactly ACTIVE consecutive cycles. The stored pixels leave in arrival order, with none lost and none repeated while the FIFO neither overflows nor underflows.
- R4: When the FIFO occupancy on the last active cycle exceeds TARGET+DEADBAND, the next blanking interval is LINE_LEN-ACTIVE-1 cycles long. With an input faster than the output, shortened blankings appear and lengthened ones do not.
- R5: When that occupancy is below TARGET-DEADBAND, the next blanking interval is LINE_LEN-ACTIVE+1 cycles long. With an input slower than the output, lengthened blankings appear and shortened ones do not.
- R6: When that occupancy lies within TARGET±DEADBAND, the blanking interval is LINE_LEN-ACTIVE cycles long. With an exactly matched input rate, every blanking has the nominal length.
- R7: Every blanking interval is LINE_LEN-ACTIVE-1, LINE_LEN-ACTIVE or LINE_LEN-ACTIVE+1 cycles long. The time between consecutive rising edges of `out_hsync` is therefore LINE_LEN-1, LINE_LEN or LINE_LEN+1 cycles.
- R8: `out_hsync` is high for exactly HS_LEN cycles at the start of each blanking interval, and it is never high together with `out_active`.
- R9: `out_data` equals BLANK_VAL whenever `out_active` is low. It also equals BLANK_VAL on any active cycle where the FIFO is empty, and such a cycle sets `udf_flag`, which stays high until reset.
- R10: A pixel offered while the FIFO holds 2**AW pixels is dropped and sets `ovf_flag`, which stays high until reset.
- R11: During reset and right after it, `out_active`, `out_hsync`, `ovf_flag` and `udf_flag` are low and `out_data` equals BLANK_VAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-frequency system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Pixel from the decoding core |
| in_valid | input | 1 | `in_data` carries a pixel this cycle |
| in_sol | input | 1 | The pixel this cycle is the first of a line |
| out_data | output | DW | Output pixel, BLANK_VAL outside active video or when starved |
| out_active | output | 1 | Active video region |
| out_hsync | output | 1 | Horizontal sync pulse at the start of blanking |
| ovf_flag | output | 1 | Sticky: a pixel was dropped because the FIFO was full |
| udf_flag | output | 1 | Sticky: an active cycle found the FIFO empty |

## Verification
The main function is tried with three input rates: exactly matched, slightly fast and slightly slow. The matched rate shows that the deadband keeps every blanking at its nominal length. The fast and slow rates show that the slip goes only in the direction the occupancy calls for, and only by one cycle. A short startup burst separates marker alignment, the target wait and the blank value sent when the FIFO is starved. A saturating input drives the FIFO into overflow, which shows that the overflow flag is sticky and that line timing keeps its bounds under that stress.

// File: rtl/slip_out_buffer.sv
`timescale 1ns/1ps
module slip_out_buffer #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int LINE_LEN = 40,
  parameter int ACTIVE = 24,
  parameter int HS_LEN = 4,
  parameter int TARGET = 8,
  parameter int DEADBAND = 3,
  parameter logic [DW-1:0] BLANK_VAL = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_sol,
  output logic [DW-1:0] out_data,
  output logic          out_active,
  output logic          out_hsync,
  output logic          ovf_flag,
  output logic          udf_flag
);
  localparam int DEPTH = 1 << AW;
  localparam int NOM_BLANK = LINE_LEN - ACTIVE;
  localparam int CW = $clog2(LINE_LEN + 2);
  localparam logic [AW:0] OCC_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] OCC_TGT  = (AW+1)'(TARGET);
  localparam logic [AW:0] OCC_HI   = (AW+1)'(TARGET + DEADBAND);
  localparam logic [AW:0] OCC_LO   = (AW+1)'(TARGET - DEADBAND);
  localparam logic [CW-1:0] BL_NOM   = CW'(NOM_BLANK);
  localparam logic [CW-1:0] BL_SHORT = CW'(NOM_BLANK - 1);
  localparam logic [CW-1:0] BL_LONG  = CW'(NOM_BLANK + 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(ACTIVE - 1);
  localparam logic [CW-1:0] HS_LIM   = CW'(HS_LEN);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          aligned, started, act_ph;
  logic [CW-1:0] cnt, blen, next_len;

  wire full   = (count == OCC_FULL);
  wire empty  = (count == '0);
  wire accept = in_valid && (aligned || in_sol);
  wire wr     = accept && !full;
  wire rd     = out_active && !empty;

  assign out_active = started && act_ph;
  assign out_hsync  = started && !act_ph && (cnt < HS_LIM);
  assign out_data   = rd ? mem[rptr] : BLANK_VAL;

  always_comb begin
    if (count > OCC_HI)      next_len = BL_SHORT;
    else if (count < OCC_LO) next_len = BL_LONG;
    else                     next_len = BL_NOM;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
      aligned <= 1'b0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (in_valid && in_sol) aligned <= 1'b1;
      if (wr) wptr <= wptr + 1'b1;
      if (rd) rptr <= rptr + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
      if (accept && full) ovf_flag <= 1'b1;
      if (out_active && empty) udf_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      act_ph <= 1'b0;
      cnt <= '0;
      blen <= BL_NOM;
    end else if (!started) begin
      if (count >= OCC_TGT) begin
        started <= 1'b1;
        act_ph <= 1'b0;
        cnt <= '0;
        blen <= next_len;
      end
    end else if (!act_ph) begin
      if (cnt == blen - 1'b1) begin
        act_ph <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == ACT_LAST) begin
        act_ph <= 1'b0;
        cnt <= '0;
        blen <= next_len;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module slip_out_buffer_chk #(
  parameter int DW = 8,
  parameter int LINE_LEN = 40,
  parameter int ACTIVE = 24,
  parameter logic [DW-1:0] BLANK_VAL = 8'h10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] out_data,
  input logic          out_active,
  input logic          out_hsync,
  input logic          ovf_flag,
  input logic          udf_flag
);
  localparam int NOM_BLANK = LINE_LEN - ACTIVE;
  logic [15:0] run_q, gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      gap_q <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q <= out_active ? run_q + 1'b1 : '0;
      gap_q <= out_active ? '0 : gap_q + 1'b1;
      if (out_active) seen_q <= 1'b1;
    end
  end

  a_r3_active_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_active) |-> run_q == 16'(ACTIVE));
  a_r7_blank_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_active) && seen_q) |->
      (gap_q >= 16'(NOM_BLANK - 1) && gap_q <= 16'(NOM_BLANK + 1)));
  a_r8_hsync_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hsync && out_active));
  a_r9_blank_value: assert property (@(posedge clk) disable iff (!rst_n)
    !out_active |-> out_data == BLANK_VAL);
  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
endmodule

bind slip_out_buffer slip_out_buffer_chk #(
  .DW(DW), .LINE_LEN(LINE_LEN), .ACTIVE(ACTIVE), .BLANK_VAL(BLANK_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_active(out_active),
  .out_hsync(out_hsync), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/slip_out_buffer_tb.sv
`timescale 1ns/1ps
module slip_out_buffer_tb;
  localparam int LINE_LEN = 40;
  localparam int ACTIVE = 24;
  localparam int NOM = LINE_LEN - ACTIVE;
  localparam int HS_LEN = 4;
  localparam logic [7:0] BLANK = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_sol = 1'b0;
  logic [7:0] out_data;
  logic out_active, out_hsync, ovf_flag, udf_flag;

  always #2 clk = ~clk;

  slip_out_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_sol(in_sol),
    .out_data(out_data), .out_active(out_active), .out_hsync(out_hsync),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] v);
    logic [7:0] r;
    r = v + 8'd1;
    if (r == BLANK) r = r + 8'd1;
    return r;
  endfunction

  // monitor state
  bit pact, phs, have_hs, first_seen;
  int rc, hc, hw, cyc, last_hs;
  int n_act, n_hsr, n_short, n_nom, n_long, n_badgap, n_badrun, n_runs;
  int n_badper, n_badhs, n_overlap, n_badblank, n_order, n_good, first_gap, first_pix;
  logic [7:0] exp_pix;

  task automatic clr_stats();
    pact = 0; phs = 0; have_hs = 0; first_seen = 0;
    rc = 0; hc = 0; hw = 0; cyc = 0; last_hs = 0;
    n_act = 0; n_hsr = 0; n_short = 0; n_nom = 0; n_long = 0; n_badgap = 0;
    n_badrun = 0; n_runs = 0; n_badper = 0; n_badhs = 0; n_overlap = 0;
    n_badblank = 0; n_order = 0; n_good = 0; first_gap = -1; first_pix = -1;
    exp_pix = 8'h01;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (out_hsync && out_active) n_overlap++;
      if (!out_active && out_data != BLANK) n_badblank++;
      if (out_hsync && !phs) begin
        n_hsr++;
        if (have_hs && ((cyc - last_hs) < LINE_LEN - 1 || (cyc - last_hs) > LINE_LEN + 1))
          n_badper++;
        have_hs = 1; last_hs = cyc; hc = 0; hw = 0;
      end
      if (!out_hsync && phs && hw != HS_LEN) n_badhs++;
      if (out_active && !pact) begin
        if (first_gap < 0) first_gap = hc;
        if (hc == NOM - 1) n_short++;
        else if (hc == NOM) n_nom++;
        else if (hc == NOM + 1) n_long++;
        else n_badgap++;
      end
      if (!out_active && pact) begin
        n_runs++;
        if (rc != ACTIVE) n_badrun++;
        rc = 0;
      end
      if (out_active) begin
        n_act++; rc++;
        if (out_data != BLANK) begin
          n_good++;
          if (!first_seen) begin first_seen = 1; first_pix = int'(out_data); end
          if (out_data != exp_pix) n_order++;
          exp_pix = nxt(out_data);
        end
      end
      hc++;
      if (out_hsync) hw++;
      pact = out_active; phs = out_hsync;
    end
  end

  logic [7:0] dv;
  int acc, pc;

  task automatic do_reset();
    rst_n = 0; in_valid = 0; in_sol = 0;
    repeat (3) @(posedge clk);
    clr_stats();
    dv = 8'h01; acc = 0; pc = 0;
    #1 rst_n = 1;
  endtask

  task automatic push(input logic [7:0] v, input bit s);
    in_valid = 1; in_data = v; in_sol = s;
    @(posedge clk); #1;
    in_valid = 0; in_sol = 0;
  endtask

  task automatic feed(input int cycles, input int rate);
    for (int i = 0; i < cycles; i++) begin
      acc += rate;
      if (acc >= LINE_LEN) begin
        acc -= LINE_LEN;
        in_valid = 1; in_data = dv; in_sol = (pc % ACTIVE == 0);
        pc++; dv = nxt(dv);
      end else begin
        in_valid = 0; in_sol = 0;
      end
      @(posedge clk); #1;
    end
    in_valid = 0; in_sol = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!out_active && !out_hsync, "R11 idle in reset", {out_active, out_hsync}, 0);
    chk(!ovf_flag && !udf_flag, "R11 flags in reset", {ovf_flag, udf_flag}, 0);
    chk(out_data == BLANK, "R11 data in reset", out_data, BLANK);
    do_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_active && !out_hsync && !ovf_flag && !udf_flag, "R11 after reset",
        {out_active, out_hsync, ovf_flag, udf_flag}, 0);
  endtask

  task automatic t_startup();
    do_reset();
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), 0);
    repeat (30) @(posedge clk); #1;
    chk(n_hsr == 0 && n_act == 0, "R1 unmarked pixels not stored", n_hsr + n_act, 0);
    push(8'h01, 1);
    for (int i = 2; i <= 7; i++) push(8'(i), 0);
    repeat (10) @(posedge clk); #1;
    chk(n_hsr == 0 && n_act == 0, "R2 wait below target", n_hsr + n_act, 0);
    push(8'h08, 0);
    repeat (60) @(posedge clk); #1;
    chk(n_hsr >= 1, "R2 first line started", n_hsr, 1);
    chk(first_gap == NOM, "R2 first blanking nominal", first_gap, NOM);
    chk(first_pix == 1, "R1 first output pixel is marked one", first_pix, 1);
    chk(n_runs >= 1 && n_badrun == 0, "R3 active run length", n_badrun, 0);
    chk(n_good == 8 && n_order == 0, "R3 pixels in order", n_good, 8);
    chk(udf_flag == 1'b1, "R9 underflow flag", udf_flag, 1);
    chk(n_act - n_good >= ACTIVE - 8, "R9 starved cycles show blank", n_act - n_good, ACTIVE - 8);
    chk(ovf_flag == 1'b0, "R10 no overflow at startup", ovf_flag, 0);
  endtask

  task automatic t_matched();
    do_reset();
    feed(LINE_LEN * 22, ACTIVE);
    chk(n_short == 0 && n_long == 0 && n_badgap == 0, "R6 no slip at matched rate",
        n_short + n_long + n_badgap, 0);
    chk(n_nom >= 15, "R6 nominal blankings", n_nom, 15);
    chk(n_badrun == 0 && n_order == 0, "R3 runs and order at matched rate", n_badrun + n_order, 0);
    chk(!ovf_flag && !udf_flag, "R9 R10 no flags at matched rate", {ovf_flag, udf_flag}, 0);
    chk(n_badper == 0, "R7 line period bound", n_badper, 0);
    chk(n_badhs == 0 && n_overlap == 0, "R8 hsync width and exclusion", n_badhs + n_overlap, 0);
    chk(n_badblank == 0, "R9 blank value outside active", n_badblank, 0);
  endtask

  task automatic t_fast();
    do_reset();
    feed(LINE_LEN * 8, ACTIVE + 2);
    chk(n_short >= 1, "R4 shortened blanking seen", n_short, 1);
    chk(n_long == 0, "R4 no lengthened blanking", n_long, 0);
    chk(n_badgap == 0 && n_badper == 0, "R7 bounds at fast rate", n_badgap + n_badper, 0);
    chk(n_badrun == 0 && n_order == 0 && !ovf_flag, "R3 order at fast rate", n_badrun + n_order, 0);
  endtask

  task automatic t_slow();
    do_reset();
    feed(LINE_LEN * 8, ACTIVE - 2);
    chk(n_long >= 1, "R5 lengthened blanking seen", n_long, 1);
    chk(n_short == 0, "R5 no shortened blanking", n_short, 0);
    chk(n_badgap == 0 && n_badper == 0, "R7 bounds at slow rate", n_badgap + n_badper, 0);
    chk(n_badrun == 0 && n_order == 0, "R3 order at slow rate", n_badrun + n_order, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    feed(200, LINE_LEN);
    chk(ovf_flag == 1'b1, "R10 overflow flag set", ovf_flag, 1);
    repeat (100) @(posedge clk); #1;
    chk(ovf_flag == 1'b1, "R10 overflow flag sticky", ovf_flag, 1);
    chk(n_badgap == 0 && n_badrun == 0, "R7 bounds under overflow", n_badgap + n_badrun, 0);
  endtask

  initial begin
    clr_stats();
    t_reset();
    t_startup();
    t_matched();
    t_fast();
    t_slow();
    t_overflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule